// File: doc/BRIEF.md
# E1 Line Output Formatter

This block shapes the transmit-side output pair of an E1 line interface. It runs from an internal clock at twice the line rate. From that clock it makes the line clock output and drives two shared output pins. In bipolar mode the pins carry the positive and negative rail pulses that an upstream line encoder requests. In unipolar mode the first pin carries serial NRZ data and the second carries a status flag for an elastic jitter-attenuation FIFO. That flag warns either that the FIFO is close to full or that it is close to empty.

The configuration inputs are held static during operation. They select the line clock edge on which the pins change, optional half-period return-to-zero shaping of the rails, which FIFO condition the flag reports, and a polarity inversion for each pin. Each input sample is captured on the internal clock edge that produces the selected line clock transition, so no derived clock is used to register the pins.

Top module: `e1_line_fmt`

## Requirements
- R1: `line_clk` is 0 while `rst` is high and toggles on every rising edge of `clk` after reset is released.
- R2: The pins change only at the line clock edge selected by `cfg_rise_edge` (1 = rising, 0 = falling). On that edge they show the inputs that were present just before it. An input change made between two selected edges does not reach the pins.
- R3: With `cfg_unipolar` = 0, `pin_a` carries `pos_req` and `pin_b` carries `neg_req`. When neither request is asserted, both rails are 0.
- R4: With `cfg_unipolar` = 1, `pin_a` carries `ser_data` and `pin_b` carries the FIFO flag.
- R5: With `cfg_flag_full` = 1, the flag is 1 exactly when `fifo_level` >= FIFO_DEPTH-4. With `cfg_flag_full` = 0, it is 1 exactly when `fifo_level` <= 4.
- R6: In NRZ operation a pin value is held for a full line clock period, across the line clock edge that is not selected.
- R7: When `cfg_rz` = 1, `cfg_unipolar` = 0 and `cfg_rise_edge` = 0, a requested rail is active for the half period after the falling line clock edge. It returns to 0 at the following rising edge.
- R8: When `cfg_unipolar` = 1 or `cfg_rise_edge` = 1, `cfg_rz` has no effect and the pins behave as NRZ.
- R9: `cfg_inv_a` and `cfg_inv_b` each invert the final value of their own pin when set to 1. Inversion is applied after mode, shaping and flag selection.
- R10: While `rst` is high, both pins take their idle level of 0 before inversion, so each pin equals its inversion bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the line rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_unipolar | input | 1 | 1 = data plus flag on the pins, 0 = bipolar rails |
| cfg_rise_edge | input | 1 | 1 = update on rising line clock edge, 0 = falling |
| cfg_rz | input | 1 | Request half-period return-to-zero shaping |
| cfg_flag_full | input | 1 | 1 = flag near full, 0 = flag near empty |
| cfg_inv_a | input | 1 | Invert `pin_a` |
| cfg_inv_b | input | 1 | Invert `pin_b` |
| pos_req | input | 1 | Positive rail pulse request |
| neg_req | input | 1 | Negative rail pulse request |
| ser_data | input | 1 | Serial NRZ data for unipolar mode |
| fifo_level | input | LVL_W | Jitter FIFO fill level, unsigned |
| line_clk | output | 1 | Line clock output |
| pin_a | output | 1 | First multifunction pin (positive rail or data) |
| pin_b | output | 1 | Second multifunction pin (negative rail or flag) |

## Verification
The hardest behaviour to bring about from the ports is the difference between the two halves of a line clock period. To show that shaping returns to zero, or that an input change made mid-period does not reach the pins, the stimulus has to land in a known phase of `line_clk`. The bench therefore waits until it sees `line_clk` at a chosen level on a falling `clk` edge. It then drives the inputs and samples once after each of the next two internal clock edges. This lets it observe the update edge and the edge that is not selected separately. The flag thresholds are reached by driving `fifo_level` to the values just on each side of both boundaries.

// File: rtl/e1_fmt_pkg.sv
package e1_fmt_pkg;

    localparam int NEAR_GAP = 4;

    typedef struct packed {
        logic uni;
        logic rise;
        logic rz;
        logic flag_full;
        logic inv_a;
        logic inv_b;
    } fmt_cfg_t;

    typedef struct packed {
        logic a;
        logic b;
    } pin_pair_t;

    typedef enum logic {
        SHAPE_NRZ = 1'b0,
        SHAPE_RZ  = 1'b1
    } shape_e;

    function automatic shape_e shape_of(fmt_cfg_t c);
        return (c.rz && !c.uni && !c.rise) ? SHAPE_RZ : SHAPE_NRZ;
    endfunction

    function automatic pin_pair_t pick_source(fmt_cfg_t c, logic pos, logic neg,
                                              logic dat, logic flg);
        pin_pair_t p;
        if (c.uni) begin
            p.a = dat;
            p.b = flg;
        end else begin
            p.a = pos;
            p.b = neg;
        end
        return p;
    endfunction

endpackage

// File: rtl/e1_lclk_gen.sv
module e1_lclk_gen (
    input  logic clk,
    input  logic rst,
    input  logic rise_sel,
    output logic lclk,
    output logic upd_stb
);
    logic lclk_q;

    always_ff @(posedge clk) begin
        if (rst) lclk_q <= 1'b0;
        else     lclk_q <= ~lclk_q;
    end

    // The edge of clk that moves lclk to the selected level is the update edge.
    assign upd_stb = rise_sel ? ~lclk_q : lclk_q;
    assign lclk    = lclk_q;
endmodule

// File: rtl/e1_fifo_flag.sv
module e1_fifo_flag #(
    parameter int DEPTH = 64,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic [LVL_W-1:0] level,
    input  logic             sel_full,
    output logic             flag
);
    import e1_fmt_pkg::*;

    localparam logic [LVL_W-1:0] FULL_TH  = LVL_W'(DEPTH - NEAR_GAP);
    localparam logic [LVL_W-1:0] EMPTY_TH = LVL_W'(NEAR_GAP);

    logic near_full, near_empty;

    assign near_full  = (level >= FULL_TH);
    assign near_empty = (level <= EMPTY_TH);
    assign flag       = sel_full ? near_full : near_empty;
endmodule

// File: rtl/e1_pin_shaper.sv
module e1_pin_shaper
    import e1_fmt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      upd_stb,
    input  shape_e    shape,
    input  pin_pair_t nxt,
    output pin_pair_t raw
);
    pin_pair_t raw_q;

    always_ff @(posedge clk) begin
        if (rst)                    raw_q <= '0;
        else if (upd_stb)           raw_q <= nxt;
        else if (shape == SHAPE_RZ) raw_q <= '0;
    end

    assign raw = raw_q;

    p_hold_nrz_r6: assert property (@(posedge clk) disable iff (rst)
        (!upd_stb && shape == SHAPE_NRZ) |=> $stable(raw_q))
        else $error("pins moved off the update edge in NRZ");

    p_rz_return_r7: assert property (@(posedge clk) disable iff (rst)
        (!upd_stb && shape == SHAPE_RZ) |=> (raw_q == '0))
        else $error("RZ rail did not return to zero");
endmodule

// File: rtl/e1_line_fmt.sv
module e1_line_fmt #(
    parameter int FIFO_DEPTH = 64,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_unipolar,
    input  logic             cfg_rise_edge,
    input  logic             cfg_rz,
    input  logic             cfg_flag_full,
    input  logic             cfg_inv_a,
    input  logic             cfg_inv_b,
    input  logic             pos_req,
    input  logic             neg_req,
    input  logic             ser_data,
    input  logic [LVL_W-1:0] fifo_level,
    output logic             line_clk,
    output logic             pin_a,
    output logic             pin_b
);
    import e1_fmt_pkg::*;

    localparam int NPIN = 2;

    fmt_cfg_t  cfg;
    logic      upd_stb;
    logic      fifo_flag;
    pin_pair_t nxt_pair;
    pin_pair_t raw_pair;
    logic [NPIN-1:0] raw_vec, inv_vec, out_vec;

    assign cfg = '{uni: cfg_unipolar, rise: cfg_rise_edge, rz: cfg_rz,
                   flag_full: cfg_flag_full, inv_a: cfg_inv_a, inv_b: cfg_inv_b};

    e1_lclk_gen u_lclk (
        .clk      (clk),
        .rst      (rst),
        .rise_sel (cfg.rise),
        .lclk     (line_clk),
        .upd_stb  (upd_stb)
    );

    e1_fifo_flag #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_flag (
        .level    (fifo_level),
        .sel_full (cfg.flag_full),
        .flag     (fifo_flag)
    );

    assign nxt_pair = pick_source(cfg, pos_req, neg_req, ser_data, fifo_flag);

    e1_pin_shaper u_shape (
        .clk     (clk),
        .rst     (rst),
        .upd_stb (upd_stb),
        .shape   (shape_of(cfg)),
        .nxt     (nxt_pair),
        .raw     (raw_pair)
    );

    assign raw_vec = {raw_pair.b, raw_pair.a};
    assign inv_vec = {cfg.inv_b, cfg.inv_a};

    for (genvar i = 0; i < NPIN; i++) begin : g_pol
        assign out_vec[i] = raw_vec[i] ^ inv_vec[i];
    end

    assign pin_a = out_vec[0];
    assign pin_b = out_vec[1];

    p_lclk_toggle_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (line_clk != $past(line_clk)))
        else $error("line clock missed a toggle");

    p_rail_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (upd_stb && !cfg_unipolar && !pos_req && !neg_req) |=> (raw_pair == '0))
        else $error("rail active with no request");

    p_uni_data_r4: assert property (@(posedge clk) disable iff (rst)
        (upd_stb && cfg_unipolar) |=> (raw_pair.a == $past(ser_data)))
        else $error("data pin does not follow serial data");

    p_flag_full_r5: assert property (@(posedge clk) disable iff (rst)
        (upd_stb && cfg_unipolar && cfg_flag_full && fifo_level >= LVL_W'(FIFO_DEPTH - 4))
        |=> raw_pair.b)
        else $error("near-full flag missing");

    p_rz_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (!upd_stb && (cfg_unipolar || cfg_rise_edge)) |=> $stable(raw_pair))
        else $error("shaping applied outside its mode");
endmodule

// File: tb/e1_line_fmt_tb.sv
module e1_line_fmt_tb;
    localparam int CLK_P = 10;
    localparam int DEPTH = 64;
    localparam int LW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst;
    logic c_uni, c_rise, c_rz, c_full, c_inva, c_invb;
    logic pos, neg, dat;
    logic [LW-1:0] lvl;
    logic line_clk, pin_a, pin_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    e1_line_fmt #(.FIFO_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .cfg_unipolar(c_uni), .cfg_rise_edge(c_rise),
        .cfg_rz(c_rz), .cfg_flag_full(c_full), .cfg_inv_a(c_inva), .cfg_inv_b(c_invb),
        .pos_req(pos), .neg_req(neg), .ser_data(dat), .fifo_level(lvl),
        .line_clk(line_clk), .pin_a(pin_a), .pin_b(pin_b)
    );

    task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FIFO FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic align(logic lc);
        step();
        while (line_clk !== lc) step();
    endtask

    task automatic set_cfg(logic u, logic r, logic z, logic f, logic ia, logic ib);
        c_uni = u; c_rise = r; c_rz = z; c_full = f; c_inva = ia; c_invb = ib;
    endtask

    task automatic t_reset();
        set_cfg(0, 1, 0, 0, 0, 0);
        pos = 1; neg = 1; dat = 1; lvl = '0;
        rst = 1'b1;
        repeat (3) step();
        chk("R10 reset pins", {pin_b, pin_a}, 2'b00);
        chk("R1 reset line_clk", {1'b0, line_clk}, 2'b00);
        c_inva = 1; c_invb = 1;
        step();
        chk("R10 reset pins inverted", {pin_b, pin_a}, 2'b11);
        c_inva = 0; c_invb = 0;
        pos = 0; neg = 0; dat = 0;
        rst = 1'b0;
    endtask

    task automatic t_lclk();
        logic prev;
        step();
        prev = line_clk;
        for (int i = 0; i < 8; i++) begin
            step();
            chk("R1 line_clk toggles", {1'b0, line_clk}, {1'b0, ~prev});
            prev = line_clk;
        end
    endtask

    // bipolar, NRZ, chosen edge; checks update edge and the other edge
    task automatic t_bipolar(logic rise, logic p, logic n);
        set_cfg(0, rise, 0, 0, 0, 0);
        align(~rise);
        pos = p; neg = n;
        step();
        chk(rise ? "R3 rails on rising edge" : "R2 rails on falling edge",
            {pin_b, pin_a}, {n, p});
        pos = ~p; neg = ~n;
        step();
        chk("R6 R2 held across other edge", {pin_b, pin_a}, {n, p});
        step();
        chk("R2 next update edge", {pin_b, pin_a}, {~n, ~p});
    endtask

    task automatic t_rz(logic p, logic n);
        set_cfg(0, 0, 1, 0, 0, 0);
        align(1'b1);
        pos = p; neg = n;
        step();
        chk("R7 RZ first half", {pin_b, pin_a}, {n, p});
        step();
        chk("R7 RZ second half", {pin_b, pin_a}, 2'b00);
    endtask

    task automatic t_rz_ignored();
        set_cfg(0, 1, 1, 0, 0, 0);
        align(1'b0);
        pos = 1; neg = 0;
        step();
        chk("R8 rise edge first half", {pin_b, pin_a}, 2'b01);
        step();
        chk("R8 rise edge no RZ", {pin_b, pin_a}, 2'b01);
        set_cfg(1, 0, 1, 0, 0, 0);
        lvl = LW'(30);
        align(1'b1);
        dat = 1;
        step();
        chk("R8 unipolar first half", {pin_b, pin_a}, 2'b01);
        step();
        chk("R8 unipolar no RZ", {pin_b, pin_a}, 2'b01);
    endtask

    task automatic t_flag(logic full, int level, logic d, logic exp_flag);
        set_cfg(1, 1, 0, full, 0, 0);
        align(1'b0);
        lvl = LW'(level); dat = d;
        step();
        chk(full ? "R5 R4 near-full flag" : "R5 R4 near-empty flag",
            {pin_b, pin_a}, {exp_flag, d});
    endtask

    task automatic t_invert();
        set_cfg(0, 1, 0, 0, 1, 0);
        align(1'b0);
        pos = 1; neg = 0;
        step();
        chk("R9 invert pin_a only", {pin_b, pin_a}, 2'b00);
        set_cfg(1, 1, 0, 1, 0, 1);
        align(1'b0);
        dat = 1; lvl = LW'(DEPTH);
        step();
        chk("R9 invert flag pin", {pin_b, pin_a}, 2'b01);
        set_cfg(0, 0, 1, 0, 1, 1);
        align(1'b1);
        pos = 1; neg = 0;
        step();
        chk("R9 invert RZ first half", {pin_b, pin_a}, 2'b10);
        step();
        chk("R9 invert RZ second half", {pin_b, pin_a}, 2'b11);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        step();
        t_reset();
        t_lclk();
        t_bipolar(1'b1, 1'b1, 1'b0);
        t_bipolar(1'b1, 1'b0, 1'b1);
        t_bipolar(1'b0, 1'b1, 1'b0);
        t_bipolar(1'b0, 1'b0, 1'b0);
        t_rz(1'b1, 1'b0);
        t_rz(1'b0, 1'b1);
        t_rz(1'b0, 1'b0);
        t_rz_ignored();
        t_flag(1'b1, DEPTH - 4, 1'b1, 1'b1);
        t_flag(1'b1, DEPTH - 5, 1'b0, 1'b0);
        t_flag(1'b1, DEPTH,     1'b0, 1'b1);
        t_flag(1'b0, 4,         1'b0, 1'b1);
        t_flag(1'b0, 5,         1'b1, 1'b0);
        t_flag(1'b0, 0,         1'b1, 1'b1);
        t_invert();
        finish_run();
    end
endmodule